// File: doc/BRIEF.md
# Pipeline ALU Operand Forwarding Unit

This block is the combinational bypass selector for a five-stage in-order integer pipeline. For each ALU source operand of the instruction now in execute, it compares the source register number with the destination of the instruction one stage ahead (held in the memory-stage register) and with the destination of the instruction two stages ahead (held in the writeback-stage register). It then produces a 2-bit select per operand and drives the selected operand value into the ALU.

A producer one stage ahead that is a load cannot supply its data in time. The unit never forwards from it, and leaves that case to the separate stall logic.

A second, smaller path serves a load that is directly followed by a store of the loaded register. The loaded value sitting in writeback is steered into the store-data input of the memory stage, so that pair needs no bubble.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select `fwd_sel_o[k]` uses the code 2'b00 for the register-file value, 2'b01 for the memory-stage ALU result and 2'b10 for the writeback value, and it never takes 2'b11. Operand index 0 feeds ALU input A and index 1 feeds ALU input B.
- R2: An operand selects 2'b01 when all of these hold: `mem_we_i`=1, `mem_is_load_i`=0, `mem_rd_i`!=0 and `mem_rd_i` equals the operand's source register.
- R3: An operand selects 2'b10 when all of these hold: `wb_we_i`=1, `wb_rd_i`!=0, `wb_rd_i` equals the source register, and the memory stage is not writing that same register.
- R4: When both stages write the operand's source register, the memory-stage result (2'b01) wins.
- R5: Register 0 is never forwarded, and a stage whose write flag is clear is never forwarded. In those cases the select is 2'b00 and the operand value is the register-file value.
- R6: When the memory stage holds a load (`mem_is_load_i`=1) writing the source register, the select is 2'b00. This holds even if writeback also writes that register.
- R7: `op_data_o[k]` equals the source named by `fwd_sel_o[k]`: `ex_rf_data_i[k]`, `mem_alu_res_i` or `wb_data_i`.
- R8: `st_fwd_o`=1 and `st_data_o`=`wb_data_i` when all of these hold: `mem_is_store_i`=1, `wb_we_i`=1, `wb_is_load_i`=1, `wb_rd_i`!=0 and `wb_rd_i`==`mem_rs2_i`. Otherwise `st_fwd_o`=0 and `st_data_o`=`mem_st_data_i`.
- R9: The two operands are resolved independently; one may forward from writeback while the other forwards from the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | NUM_OPS x REG_AW | Source register numbers of the execute-stage instruction |
| ex_rf_data_i | input | NUM_OPS x XLEN | Register-file values read for those sources |
| mem_rd_i | input | REG_AW | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_is_load_i | input | 1 | Memory-stage instruction is a load |
| mem_alu_res_i | input | XLEN | Memory-stage ALU result |
| mem_is_store_i | input | 1 | Memory-stage instruction is a store |
| mem_rs2_i | input | REG_AW | Store-data source register of the memory-stage store |
| mem_st_data_i | input | XLEN | Store data carried down from execute |
| wb_rd_i | input | REG_AW | Destination register of the writeback-stage instruction |
| wb_we_i | input | 1 | Writeback-stage instruction writes a register |
| wb_is_load_i | input | 1 | Writeback-stage instruction is a load |
| wb_data_i | input | XLEN | Value being written back |
| fwd_sel_o | output | NUM_OPS x 2 | Per-operand bypass select |
| op_data_o | output | NUM_OPS x XLEN | Selected ALU operand values |
| st_data_o | output | XLEN | Store data for the memory stage |
| st_fwd_o | output | 1 | Store data taken from writeback |

## Verification
A table of directed patterns covers the main cases one at a time:
- a single match in either stage;
- matches in both stages, which separates the priority rule from plain match detection;
- register 0 and cleared write flags, which expose missing qualifiers;
- a load in the memory stage, which shows whether the fallback to writeback is wrongly taken;
- crossed operands, which catch operand swaps.

Register values are distinct per source, so a data check shows which multiplexer leg was taken. A randomized run over a narrow register range then compares both operands against a priority model. The store path is probed with each qualifier removed in turn.

// File: rtl/fwd_pkg.sv
`timescale 1ns/1ps
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EXM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_hit.sv
`timescale 1ns/1ps
// Producer/consumer register match, qualified by write flag and nonzero dest
module fwd_hit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src_i,
  input  logic [REG_AW-1:0] dst_i,
  input  logic              we_i,
  output logic              hit_o
);
  assign hit_o = we_i && (dst_i != '0) && (dst_i == src_i);
endmodule

// File: rtl/fwd_op_sel.sv
`timescale 1ns/1ps
module fwd_op_sel
  import fwd_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs_i,
  input  logic [XLEN-1:0]   rf_data_i,
  input  logic [REG_AW-1:0] mem_rd_i,
  input  logic              mem_we_i,
  input  logic              mem_is_load_i,
  input  logic [XLEN-1:0]   mem_alu_res_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  input  logic [XLEN-1:0]   wb_data_i,
  output fwd_sel_e          sel_o,
  output logic [XLEN-1:0]   data_o
);
  logic mem_hit, wb_hit;

  fwd_hit #(.REG_AW(REG_AW)) u_mem_hit (
    .src_i(rs_i), .dst_i(mem_rd_i), .we_i(mem_we_i), .hit_o(mem_hit)
  );
  fwd_hit #(.REG_AW(REG_AW)) u_wb_hit (
    .src_i(rs_i), .dst_i(wb_rd_i), .we_i(wb_we_i), .hit_o(wb_hit)
  );

  // Younger producer shadows older; a younger load blocks both (stall covers it)
  always_comb begin
    if (mem_hit)     sel_o = mem_is_load_i ? FWD_RF : FWD_EXM;
    else if (wb_hit) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

  always_comb begin
    unique case (sel_o)
      FWD_EXM: data_o = mem_alu_res_i;
      FWD_WB:  data_o = wb_data_i;
      default: data_o = rf_data_i;
    endcase
  end
endmodule

// File: rtl/fwd_st_path.sv
`timescale 1ns/1ps
// Writeback-to-memory store data bypass for load followed by store
module fwd_st_path #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input  logic              mem_is_store_i,
  input  logic [REG_AW-1:0] mem_rs2_i,
  input  logic [XLEN-1:0]   mem_st_data_i,
  input  logic [REG_AW-1:0] wb_rd_i,
  input  logic              wb_we_i,
  input  logic              wb_is_load_i,
  input  logic [XLEN-1:0]   wb_data_i,
  output logic [XLEN-1:0]   st_data_o,
  output logic              st_fwd_o
);
  logic ld_we;
  assign ld_we = wb_we_i && wb_is_load_i && mem_is_store_i;

  fwd_hit #(.REG_AW(REG_AW)) u_st_hit (
    .src_i(mem_rs2_i), .dst_i(wb_rd_i), .we_i(ld_we), .hit_o(st_fwd_o)
  );

  assign st_data_o = st_fwd_o ? wb_data_i : mem_st_data_i;
endmodule

// File: rtl/fwd_unit.sv
`timescale 1ns/1ps
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_AW  = 5,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][REG_AW-1:0] ex_rs_i,
  input  logic [NUM_OPS-1:0][XLEN-1:0]   ex_rf_data_i,
  input  logic [REG_AW-1:0]              mem_rd_i,
  input  logic                           mem_we_i,
  input  logic                           mem_is_load_i,
  input  logic [XLEN-1:0]                mem_alu_res_i,
  input  logic                           mem_is_store_i,
  input  logic [REG_AW-1:0]              mem_rs2_i,
  input  logic [XLEN-1:0]                mem_st_data_i,
  input  logic [REG_AW-1:0]              wb_rd_i,
  input  logic                           wb_we_i,
  input  logic                           wb_is_load_i,
  input  logic [XLEN-1:0]                wb_data_i,
  output logic [NUM_OPS-1:0][1:0]        fwd_sel_o,
  output logic [NUM_OPS-1:0][XLEN-1:0]   op_data_o,
  output logic [XLEN-1:0]                st_data_o,
  output logic                           st_fwd_o
);
  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_sel_e sel;
    fwd_op_sel #(.XLEN(XLEN), .REG_AW(REG_AW)) u_sel (
      .rs_i         (ex_rs_i[g]),
      .rf_data_i    (ex_rf_data_i[g]),
      .mem_rd_i     (mem_rd_i),
      .mem_we_i     (mem_we_i),
      .mem_is_load_i(mem_is_load_i),
      .mem_alu_res_i(mem_alu_res_i),
      .wb_rd_i      (wb_rd_i),
      .wb_we_i      (wb_we_i),
      .wb_data_i    (wb_data_i),
      .sel_o        (sel),
      .data_o       (op_data_o[g])
    );
    assign fwd_sel_o[g] = sel;
  end

  fwd_st_path #(.XLEN(XLEN), .REG_AW(REG_AW)) u_st (
    .mem_is_store_i(mem_is_store_i),
    .mem_rs2_i     (mem_rs2_i),
    .mem_st_data_i (mem_st_data_i),
    .wb_rd_i       (wb_rd_i),
    .wb_we_i       (wb_we_i),
    .wb_is_load_i  (wb_is_load_i),
    .wb_data_i     (wb_data_i),
    .st_data_o     (st_data_o),
    .st_fwd_o      (st_fwd_o)
  );
endmodule

// File: rtl/fwd_unit_chk.sv
`timescale 1ns/1ps
module fwd_unit_chk #(
  parameter int XLEN    = 32,
  parameter int REG_AW  = 5,
  parameter int NUM_OPS = 2
) (
  input logic [NUM_OPS-1:0][REG_AW-1:0] ex_rs_i,
  input logic [NUM_OPS-1:0][XLEN-1:0]   ex_rf_data_i,
  input logic [REG_AW-1:0]              mem_rd_i,
  input logic                           mem_we_i,
  input logic                           mem_is_load_i,
  input logic [XLEN-1:0]                mem_alu_res_i,
  input logic                           mem_is_store_i,
  input logic [REG_AW-1:0]              mem_rs2_i,
  input logic [XLEN-1:0]                mem_st_data_i,
  input logic [REG_AW-1:0]              wb_rd_i,
  input logic                           wb_we_i,
  input logic                           wb_is_load_i,
  input logic [XLEN-1:0]                wb_data_i,
  input logic [NUM_OPS-1:0][1:0]        fwd_sel_o,
  input logic [NUM_OPS-1:0][XLEN-1:0]   op_data_o,
  input logic [XLEN-1:0]                st_data_o,
  input logic                           st_fwd_o
);
  always_comb begin
    for (int k = 0; k < NUM_OPS; k++) begin
      a_r1_sel_legal: assert (fwd_sel_o[k] != 2'b11)
        else $error("R1 illegal select on operand %0d", k);
      a_r2_exm_source: assert (fwd_sel_o[k] != 2'b01 ||
        (mem_we_i && !mem_is_load_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i[k]
         && op_data_o[k] == mem_alu_res_i))
        else $error("R2 bad memory-stage forward on operand %0d", k);
      a_r3_wb_source: assert (fwd_sel_o[k] != 2'b10 ||
        (wb_we_i && wb_rd_i != '0 && wb_rd_i == ex_rs_i[k]
         && !(mem_we_i && mem_rd_i == ex_rs_i[k]) && op_data_o[k] == wb_data_i))
        else $error("R3 bad writeback forward on operand %0d", k);
      a_r4_priority: assert (!(mem_we_i && !mem_is_load_i && mem_rd_i != '0 &&
        mem_rd_i == ex_rs_i[k]) || fwd_sel_o[k] == 2'b01)
        else $error("R4 memory-stage priority lost on operand %0d", k);
      a_r5_zero_reg: assert (ex_rs_i[k] != '0 ||
        (fwd_sel_o[k] == 2'b00 && op_data_o[k] == ex_rf_data_i[k]))
        else $error("R5 register 0 forwarded on operand %0d", k);
      a_r6_load_blocks: assert (!(mem_we_i && mem_is_load_i && mem_rd_i != '0 &&
        mem_rd_i == ex_rs_i[k]) || fwd_sel_o[k] == 2'b00)
        else $error("R6 forward past a load on operand %0d", k);
    end
    a_r8_store_flag: assert (st_fwd_o == (mem_is_store_i && wb_we_i && wb_is_load_i
      && wb_rd_i != '0 && wb_rd_i == mem_rs2_i))
      else $error("R8 store forward flag wrong");
    a_r8_store_data: assert (st_data_o == (st_fwd_o ? wb_data_i : mem_st_data_i))
      else $error("R8 store data wrong");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW), .NUM_OPS(NUM_OPS)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  localparam int XLEN = 32, AW = 5, NOPS = 2;
  localparam logic [XLEN-1:0] MEM_V = 32'h1111_1111, WB_V = 32'h2222_2222;
  localparam logic [XLEN-1:0] ST_V = 32'h5555_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NOPS-1:0][AW-1:0]   ex_rs;
  logic [NOPS-1:0][XLEN-1:0] rf_data, op_data;
  logic [AW-1:0]             mem_rd, mem_rs2, wb_rd;
  logic                      mem_we, mem_ld, mem_st, wb_we, wb_ld, st_fwd;
  logic [XLEN-1:0]           mem_alu, mem_st_data, wb_data, st_data;
  logic [NOPS-1:0][1:0]      sel;

  fwd_unit #(.XLEN(XLEN), .REG_AW(AW), .NUM_OPS(NOPS)) u0 (
    .ex_rs_i(ex_rs), .ex_rf_data_i(rf_data), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .mem_is_load_i(mem_ld), .mem_alu_res_i(mem_alu), .mem_is_store_i(mem_st),
    .mem_rs2_i(mem_rs2), .mem_st_data_i(mem_st_data), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .wb_is_load_i(wb_ld), .wb_data_i(wb_data), .fwd_sel_o(sel), .op_data_o(op_data),
    .st_data_o(st_data), .st_fwd_o(st_fwd)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [AW-1:0] rs, input logic [AW-1:0] mrd,
      input logic mwe, input logic mld, input logic [AW-1:0] wrd, input logic wwe);
    if (mwe && mrd != 0 && mrd == rs) return mld ? 2'b00 : 2'b01;
    if (wwe && wrd != 0 && wrd == rs) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] ref_data(input logic [1:0] s, input int k);
    case (s)
      2'b01:   return MEM_V;
      2'b10:   return WB_V;
      default: return 32'hA000_0000 + k;
    endcase
  endfunction

  // {rs0, rs1, mem_rd, mem_we, mem_ld, wb_rd, wb_we, exp_sel0, exp_sel1}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {5'd0,  5'd0,  5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 2'b00, 2'b00}, // R5 idle
    {5'd3,  5'd4,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 2'b01, 2'b00}, // R2
    {5'd5,  5'd6,  5'd9,  1'b1, 1'b0, 5'd6,  1'b1, 2'b00, 2'b10}, // R3
    {5'd7,  5'd7,  5'd7,  1'b1, 1'b0, 5'd7,  1'b1, 2'b01, 2'b01}, // R4
    {5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 2'b00, 2'b00}, // R5 reg 0
    {5'd8,  5'd8,  5'd8,  1'b0, 1'b0, 5'd8,  1'b0, 2'b00, 2'b00}, // R5 we clear
    {5'd10, 5'd11, 5'd10, 1'b1, 1'b1, 5'd10, 1'b1, 2'b00, 2'b00}, // R6
    {5'd12, 5'd13, 5'd12, 1'b1, 1'b1, 5'd13, 1'b1, 2'b00, 2'b10}, // R6 other op
    {5'd14, 5'd15, 5'd15, 1'b1, 1'b0, 5'd14, 1'b1, 2'b10, 2'b01}, // R9
    {5'd16, 5'd16, 5'd16, 1'b0, 1'b0, 5'd16, 1'b1, 2'b10, 2'b10}  // R3 mem we clear
  };

  task automatic set_ops(input logic [AW-1:0] r0, input logic [AW-1:0] r1,
      input logic [AW-1:0] mrd, input logic mwe, input logic mld,
      input logic [AW-1:0] wrd, input logic wwe);
    @(posedge clk);
    ex_rs[0] = r0; ex_rs[1] = r1;
    mem_rd = mrd; mem_we = mwe; mem_ld = mld; wb_rd = wrd; wb_we = wwe;
    @(negedge clk);
  endtask

  task automatic set_st(input logic st, input logic [AW-1:0] rs2,
      input logic [AW-1:0] wrd, input logic wwe, input logic wld);
    @(posedge clk);
    mem_st = st; mem_rs2 = rs2; wb_rd = wrd; wb_we = wwe; wb_ld = wld;
    @(negedge clk);
  endtask

  initial begin
    ex_rs = '0; mem_rd = '0; mem_rs2 = '0; wb_rd = '0;
    mem_we = 0; mem_ld = 0; mem_st = 0; wb_we = 0; wb_ld = 0;
    rf_data[0] = 32'hA000_0000; rf_data[1] = 32'hA000_0001;
    mem_alu = MEM_V; wb_data = WB_V; mem_st_data = ST_V;
    repeat (3) @(negedge clk);
    chk("R1 reset sel0", 32'(sel[0]), 32'h0);
    chk("R1 reset sel1", 32'(sel[1]), 32'h0);
    chk("R8 reset st_fwd", 32'(st_fwd), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v = VEC[i];
      set_ops(v[26:22], v[21:17], v[16:12], v[11], v[10], v[9:5], v[4]);
      chk($sformatf("R1/R2/R3/R4/R5/R6/R9 vec%0d sel0", i), 32'(sel[0]), 32'(v[3:2]));
      chk($sformatf("R1/R2/R3/R4/R5/R6/R9 vec%0d sel1", i), 32'(sel[1]), 32'(v[1:0]));
      chk($sformatf("R7 vec%0d data0", i), op_data[0], ref_data(v[3:2], 0));
      chk($sformatf("R7 vec%0d data1", i), op_data[1], ref_data(v[1:0], 1));
    end

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] r0, r1, mrd, wrd;
      logic mwe, mld, wwe;
      logic [1:0] e0, e1;
      r0 = AW'($urandom_range(0, 3)); r1 = AW'($urandom_range(0, 3));
      mrd = AW'($urandom_range(0, 3)); wrd = AW'($urandom_range(0, 3));
      mwe = 1'($urandom); mld = 1'($urandom); wwe = 1'($urandom);
      set_ops(r0, r1, mrd, mwe, mld, wrd, wwe);
      e0 = ref_sel(r0, mrd, mwe, mld, wrd, wwe);
      e1 = ref_sel(r1, mrd, mwe, mld, wrd, wwe);
      chk($sformatf("R2/R3/R4/R5/R6 rand%0d sel0", i), 32'(sel[0]), 32'(e0));
      chk($sformatf("R2/R3/R4/R5/R6 rand%0d sel1", i), 32'(sel[1]), 32'(e1));
      chk($sformatf("R7 rand%0d data0", i), op_data[0], ref_data(e0, 0));
      chk($sformatf("R7 rand%0d data1", i), op_data[1], ref_data(e1, 1));
    end

    // R8 store path: hit, then each qualifier removed
    set_st(1, 5'd9, 5'd9, 1, 1);
    chk("R8 hit flag", 32'(st_fwd), 32'h1);
    chk("R8 hit data", st_data, WB_V);
    set_st(1, 5'd9, 5'd9, 1, 0);
    chk("R8 wb not load", st_data, ST_V);
    set_st(1, 5'd9, 5'd9, 0, 1);
    chk("R8 wb we clear", st_data, ST_V);
    set_st(0, 5'd9, 5'd9, 1, 1);
    chk("R8 not store", 32'(st_fwd), 32'h0);
    set_st(1, 5'd0, 5'd0, 1, 1);
    chk("R8 reg 0", st_data, ST_V);
    set_st(1, 5'd9, 5'd10, 1, 1);
    chk("R8 reg mismatch", 32'(st_fwd), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..all actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule